// File: doc/BRIEF.md
# Dual-Section Bidirectional Parity Transceiver

The block holds independent byte-wide transceiver sections (two by default). Each section carries a byte between its A side and its B side in the direction picked by its own mode input, without inverting any bit. While moving a byte from A to B it produces the parity bit for that byte, using odd or even sense as selected. While moving a byte from B to A it takes the parity bit in from the bus and raises a flag when the nine bits agree with the selected sense.

Every bidirectional pad is split into an input value, an output value and a drive enable, so the block synthesizes as plain logic with the pad cells outside it. The paths are purely combinational: there is no clock, no reset and no storage. A single disable input per section turns off every pad driver of that section, including the parity pin and the flag, whatever the other controls say.

Top module: `parity_xcvr`

## Requirements
- R1: Sections are independent: the outputs and drive enables of section s depend only on the inputs of section s, where section s uses bits [s*8 +: 8] of the byte buses and bit s of every per-section signal.
- R2: With `secTx`=1 and `secOff`=0 the section drives B (`bDrv`=1, `aDrv`=0) and `bOut` equals `aIn` bit for bit.
- R3: With `secTx`=0 and `secOff`=0 the section drives A (`aDrv`=1, `bDrv`=0) and `aOut` equals `bIn` bit for bit.
- R4: With `secOff`=1 none of `aDrv`, `bDrv`, `parDrv`, `okDrv` of that section is asserted, for every value of the other inputs.
- R5: When transmitting, `parOut` makes the count of ones among the eight `aIn` bits plus `parOut` odd when `secOdd`=1 and even when `secOdd`=0 (even sense with five ones gives `parOut`=1).
- R6: When receiving, `okOut` is 1 when the eight `bIn` bits plus `parIn` hold an odd count of ones with `secOdd`=1, or an even count with `secOdd`=0, and 0 otherwise (odd sense, `parIn`=1, three ones gives 0).
- R7: `parDrv` is 1 only when the section is enabled and transmitting; `okDrv` is 1 only when the section is enabled and receiving.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| secTx | input | 2 | Per-section mode: 1 moves A to B, 0 moves B to A |
| secOff | input | 2 | Per-section disable: 1 releases every pad of the section |
| secOdd | input | 2 | Per-section parity sense: 1 odd, 0 even |
| aIn | input | 16 | A-side pad input values, byte per section |
| aOut | output | 16 | A-side pad output values |
| aDrv | output | 2 | A-side drive enable per section |
| bIn | input | 16 | B-side pad input values |
| bOut | output | 16 | B-side pad output values |
| bDrv | output | 2 | B-side drive enable per section |
| parIn | input | 2 | Parity pad input value per section |
| parOut | output | 2 | Parity pad output value per section |
| parDrv | output | 2 | Parity pad drive enable per section |
| okOut | output | 2 | Parity-agreement flag value per section |
| okDrv | output | 2 | Parity-agreement flag drive enable per section |

## Verification
Parity generation and parity checking can be active at the same moment, one in each section. The bench provokes this by always giving section 1 the opposite mode and disable setting of section 0 and the complemented byte, sweeping all eight control settings, both parity inputs and all 256 byte values. Each section is judged against a popcount model of its own inputs only, so a leak of generation logic into the checking section, or of one section's controls into the other, shows as a mismatch.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes sent from the control decode to the datapath of one section.
  typedef struct packed {
    logic driveA;
    logic driveB;
    logic drivePar;
    logic driveOk;
    logic oddSense;
  } xcvr_strobe_t;

  // Reduction of a byte-wide (or wider) vector to its ones-count parity.
  function automatic logic oddOnes(input logic [63:0] v, input int width);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i < width) acc = acc ^ v[i];
    end
    return acc;
  endfunction

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         txMode,
  input  logic         offReq,
  input  logic         oddReq,
  output xcvr_strobe_t strobe
);

  logic liveSec;

  always_comb begin
    liveSec         = ~offReq;
    strobe.driveB   = liveSec & txMode;
    strobe.driveA   = liveSec & ~txMode;
    strobe.drivePar = liveSec & txMode;
    strobe.driveOk  = liveSec & ~txMode;
    strobe.oddSense = oddReq;
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  xcvr_strobe_t     strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             parIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut,
  output logic             parOut,
  output logic             okOut,
  output logic             aDrv,
  output logic             bDrv,
  output logic             parDrv,
  output logic             okDrv
);

  localparam int PadW = 64;

  logic aOdd;
  logic bOdd;
  logic [PadW-1:0] aWide;
  logic [PadW-1:0] bWide;

  always_comb begin
    aWide = '0;
    bWide = '0;
    aWide[WIDTH-1:0] = aIn;
    bWide[WIDTH-1:0] = bIn;
    aOdd = oddOnes(aWide, WIDTH);
    bOdd = oddOnes(bWide, WIDTH);
  end

  // Straight, non-inverting byte paths in both directions.
  assign bOut = aIn;
  assign aOut = bIn;

  // Generated bit brings the total count to the selected sense.
  assign parOut = aOdd ^ strobe.oddSense;

  // Received total count compared with the selected sense.
  assign okOut = (bOdd ^ parIn) == strobe.oddSense;

  assign aDrv   = strobe.driveA;
  assign bDrv   = strobe.driveB;
  assign parDrv = strobe.drivePar;
  assign okDrv  = strobe.driveOk;

endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr
  import xcvr_pkg::*;
#(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input  logic [SECTIONS-1:0]       secTx,
  input  logic [SECTIONS-1:0]       secOff,
  input  logic [SECTIONS-1:0]       secOdd,
  input  logic [SECTIONS*WIDTH-1:0] aIn,
  output logic [SECTIONS*WIDTH-1:0] aOut,
  output logic [SECTIONS-1:0]       aDrv,
  input  logic [SECTIONS*WIDTH-1:0] bIn,
  output logic [SECTIONS*WIDTH-1:0] bOut,
  output logic [SECTIONS-1:0]       bDrv,
  input  logic [SECTIONS-1:0]       parIn,
  output logic [SECTIONS-1:0]       parOut,
  output logic [SECTIONS-1:0]       parDrv,
  output logic [SECTIONS-1:0]       okOut,
  output logic [SECTIONS-1:0]       okDrv
);

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    xcvr_strobe_t strobe;

    xcvr_ctrl u_ctrl (
      .txMode (secTx[s]),
      .offReq (secOff[s]),
      .oddReq (secOdd[s]),
      .strobe (strobe)
    );

    xcvr_lane #(.WIDTH(WIDTH)) u_lane (
      .strobe (strobe),
      .aIn    (aIn[s*WIDTH +: WIDTH]),
      .bIn    (bIn[s*WIDTH +: WIDTH]),
      .parIn  (parIn[s]),
      .aOut   (aOut[s*WIDTH +: WIDTH]),
      .bOut   (bOut[s*WIDTH +: WIDTH]),
      .parOut (parOut[s]),
      .okOut  (okOut[s]),
      .aDrv   (aDrv[s]),
      .bDrv   (bDrv[s]),
      .parDrv (parDrv[s]),
      .okDrv  (okDrv[s])
    );
  end

endmodule

// File: rtl/parity_xcvr_chk.sv
module parity_xcvr_chk #(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input logic [SECTIONS-1:0]       secTx,
  input logic [SECTIONS-1:0]       secOff,
  input logic [SECTIONS-1:0]       secOdd,
  input logic [SECTIONS*WIDTH-1:0] aIn,
  input logic [SECTIONS*WIDTH-1:0] aOut,
  input logic [SECTIONS-1:0]       aDrv,
  input logic [SECTIONS*WIDTH-1:0] bIn,
  input logic [SECTIONS*WIDTH-1:0] bOut,
  input logic [SECTIONS-1:0]       bDrv,
  input logic [SECTIONS-1:0]       parIn,
  input logic [SECTIONS-1:0]       parOut,
  input logic [SECTIONS-1:0]       parDrv,
  input logic [SECTIONS-1:0]       okOut,
  input logic [SECTIONS-1:0]       okDrv
);

  for (genvar s = 0; s < SECTIONS; s++) begin : g_chk
    always_comb begin
      // R4
      off_quiet_chk: assert (!secOff[s] || !(aDrv[s] | bDrv[s] | parDrv[s] | okDrv[s]))
        else $error("section %0d drives while disabled", s);
      // R7
      par_drive_chk: assert (!parDrv[s] || (secTx[s] && !secOff[s]))
        else $error("section %0d parity driven outside transmit", s);
      // R7
      ok_drive_chk: assert (!okDrv[s] || (!secTx[s] && !secOff[s]))
        else $error("section %0d flag driven outside receive", s);
      // R2
      tx_copy_chk: assert (!bDrv[s] || (bOut[s*WIDTH +: WIDTH] == aIn[s*WIDTH +: WIDTH] && !aDrv[s]))
        else $error("section %0d transmit copy wrong", s);
      // R3
      rx_copy_chk: assert (!aDrv[s] || (aOut[s*WIDTH +: WIDTH] == bIn[s*WIDTH +: WIDTH] && !bDrv[s]))
        else $error("section %0d receive copy wrong", s);
      // R5
      tx_parity_chk: assert (!parDrv[s] || (($countones(aIn[s*WIDTH +: WIDTH]) + int'(parOut[s])) % 2 == int'(secOdd[s])))
        else $error("section %0d generated parity wrong", s);
      // R6
      rx_flag_chk: assert (!okDrv[s] || (okOut[s] == ((($countones(bIn[s*WIDTH +: WIDTH]) + int'(parIn[s])) % 2) == int'(secOdd[s]))))
        else $error("section %0d parity flag wrong", s);
    end
  end

endmodule

bind parity_xcvr parity_xcvr_chk #(.SECTIONS(SECTIONS), .WIDTH(WIDTH)) u_chk (
  .secTx  (secTx),
  .secOff (secOff),
  .secOdd (secOdd),
  .aIn    (aIn),
  .aOut   (aOut),
  .aDrv   (aDrv),
  .bIn    (bIn),
  .bOut   (bOut),
  .bDrv   (bDrv),
  .parIn  (parIn),
  .parOut (parOut),
  .parDrv (parDrv),
  .okOut  (okOut),
  .okDrv  (okDrv)
);

// File: tb/parity_xcvr_bench.sv
module parity_xcvr_bench;

  localparam int S = 2;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [S-1:0]   secTx, secOff, secOdd, parIn;
  logic [S*W-1:0] aIn, bIn;
  logic [S*W-1:0] aOut, bOut;
  logic [S-1:0]   aDrv, bDrv, parDrv, parOut, okOut, okDrv;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  parity_xcvr #(.SECTIONS(S), .WIDTH(W)) u_parity_xcvr (
    .secTx(secTx), .secOff(secOff), .secOdd(secOdd),
    .aIn(aIn), .aOut(aOut), .aDrv(aDrv),
    .bIn(bIn), .bOut(bOut), .bDrv(bDrv),
    .parIn(parIn), .parOut(parOut), .parDrv(parDrv),
    .okOut(okOut), .okDrv(okDrv)
  );

  task automatic chk(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      if (errors < 20)
        $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  function automatic int ones(input logic [W-1:0] v);
    int n = 0;
    for (int i = 0; i < W; i++) n += int'(v[i]);
    return n;
  endfunction

  // Judges one section against the arithmetic model of its own inputs.
  task automatic judge(input int s);
    logic tx, off, odd, pin;
    logic [W-1:0] a, b;
    int expPar, expOk;
    tx = secTx[s]; off = secOff[s]; odd = secOdd[s]; pin = parIn[s];
    a = aIn[s*W +: W]; b = bIn[s*W +: W];
    expPar = ((ones(a) % 2) == 1) != odd ? 1 : 0;
    expOk  = (((ones(b) + int'(pin)) % 2) == int'(odd)) ? 1 : 0;
    // R4 R2 R3: drive enables per mode; R1 via each section's own model
    chk("R4/R2 bDrv (R1)", int'(bDrv[s]), int'(!off && tx));
    chk("R4/R3 aDrv (R1)", int'(aDrv[s]), int'(!off && !tx));
    // R7
    chk("R7 parDrv", int'(parDrv[s]), int'(!off && tx));
    chk("R7 okDrv", int'(okDrv[s]), int'(!off && !tx));
    if (!off && tx) begin
      chk("R2 bOut", int'(bOut[s*W +: W]), int'(a));
      chk("R5 parOut", int'(parOut[s]), expPar);
    end
    if (!off && !tx) begin
      chk("R3 aOut", int'(aOut[s*W +: W]), int'(b));
      chk("R6 okOut", int'(okOut[s]), expOk);
    end
  endtask

  initial begin
    secTx = '0; secOff = '1; secOdd = '0; parIn = '0; aIn = '0; bIn = '0;
    @(negedge clk); #2;
    // Idle state with both sections disabled (R4)
    chk("R4 idle drives", int'({aDrv, bDrv, parDrv, okDrv}), 0);

    // Named corner cases
    @(negedge clk);
    secOff = 2'b00; secTx = 2'b01; secOdd = 2'b00; aIn = {8'h00, 8'b0001_1111};
    bIn = {8'b0000_0111, 8'h00}; parIn = 2'b10; secOdd[1] = 1'b1;
    #2;
    chk("R5 even five ones", int'(parOut[0]), 1);
    chk("R6 odd three ones par1", int'(okOut[1]), 0);

    for (int cfg = 0; cfg < 8; cfg++) begin
      for (int p = 0; p < 2; p++) begin
        for (int v = 0; v < 256; v++) begin
          @(negedge clk);
          secTx  = {~cfg[0], cfg[0]};
          secOff = {~cfg[1], cfg[1]};
          secOdd = {~cfg[2], cfg[2]};
          parIn  = {~p[0], p[0]};
          aIn = {~v[7:0], v[7:0]};
          bIn = {v[7:0] ^ 8'h5A, ~(v[7:0] ^ 8'h5A)};
          #2;
          judge(0);
          judge(1);
        end
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule